// File: doc/BRIEF.md
# Lockout Chatter and Latency Monitor

This block watches two single-bit signals from an under-voltage lockout path. One is the gate output-enable. The other is the qualified flag that reports the bias rail is below its turn-off threshold. The block produces one set of metrics for each rail excursion. A rising edge of the trip flag opens a fixed-length observation window. Inside the window the block counts every change of the output-enable. It also measures how many cycles pass before the enable is seen low. When the window closes, both numbers are compared against programmed limits. The numbers and two fail flags are then latched and announced by a one-cycle done pulse.

Alongside the per-event window, the block tracks restart storms. Each time the trip flag falls, a hold-off interval starts. A new trip that arrives inside that interval counts as a re-trip. It raises a one-cycle pulse and increments a saturating storm counter. The block is pure observation: it never drives the enable. It is meant as a built-in self-check that sits next to the lockout logic.

"Edge" below means a rising clock edge at which inputs are sampled. "Edge 0" is the edge at which the trip flag is first seen high.

Top module: `lockout_event_monitor`

## Requirements
- R1: After reset, every output is 0: done, toggle count, latency, both fail flags, storm pulse and storm count.
- R2: When no window is open, a rise of `uv_trip_i` at edge 0 opens a window. The window spans edges 0 to W-1, where W is `win_len_i` (values below 2 act as 2). `done_o` is high for exactly the one cycle after edge W-1. A trip rise while the window is open neither restarts nor extends it.
- R3: `toggles_o` is the number of window edges at which `oe_i` differs from its value at the previous edge, counting rising and falling changes alike. For edge 0 the comparison is with the value at the edge before it. Changes outside the window are not counted.
- R4: `chatter_fail_o` is 1 exactly when the toggle count is strictly greater than `tog_lim_i`.
- R5: `latency_o` is the index of the first window edge at which `oe_i` is sampled 0. It is 0 if the enable is already low at edge 0.
- R6: `latency_fail_o` is 1 in three cases: the latency exceeds `lat_lim_i`, or `oe_i` is never sampled 0 inside the window (the latency then reads W), or the latency is saturated.
- R7: The latency saturates at 2^LAT_W-1 (255 by default), and a saturated value always fails.
- R8: The four result outputs change only in the cycle in which `done_o` is high, and hold between done pulses.
- R9: A fall of `uv_trip_i` at edge r arms re-trip detection. A trip rise at edge r+d with 1 <= d <= `retrip_gap_i` gives a one-cycle `storm_o` pulse in the following cycle and adds 1 to `storm_cnt_o`. A later rise, or any rise with the gap set to 0, does neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_i | input | 1 | Observed gate output-enable |
| uv_trip_i | input | 1 | Qualified below-off-threshold flag |
| win_len_i | input | WIN_W | Window length in edges |
| tog_lim_i | input | TOG_W | Highest toggle count that passes |
| lat_lim_i | input | LAT_W | Highest latency that passes |
| retrip_gap_i | input | GAP_W | Re-trip hold-off interval in edges |
| done_o | output | 1 | One-cycle pulse when results are latched |
| toggles_o | output | TOG_W | Toggle count of the last window |
| latency_o | output | LAT_W | Disable latency of the last window |
| chatter_fail_o | output | 1 | Toggle count above limit |
| latency_fail_o | output | 1 | Latency above limit, missing or saturated |
| storm_o | output | 1 | One-cycle pulse on a re-trip inside the hold-off |
| storm_cnt_o | output | STORM_W | Saturating count of re-trips |

## Verification
The window close and the re-trip detector can act on the same edge. This happens when the trip flag rises again exactly on the last edge of an open window, inside the hold-off started by the preceding recovery. The bench builds that case with an enable change on the same closing edge. It then expects three things in the one cycle after that edge: `done_o` and `storm_o` high together, the enable change included in the toggle count, and the storm count raised by one. Because the window was still open when the trip rose, that rise must not open a second window, so `done_o` has to stay low through the following cycles.

// File: rtl/lem_pkg.sv
package lem_pkg;

   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;

endpackage

// File: rtl/lem_sampler.sv
module lem_sampler
   import lem_pkg::*;
#(
   parameter int STAGES = 0
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  oe_i,
   input  logic  trip_i,
   output logic  oe_lvl_o,
   output logic  oe_chg_o,
   output edge_t trip_e_o
);

   logic oe_s, trip_s;
   logic oe_q, trip_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign oe_s   = oe_i;
         assign trip_s = trip_i;
      end else begin : g_sync
         logic [STAGES-1:0] oe_pipe, trip_pipe;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               oe_pipe   <= '0;
               trip_pipe <= '0;
            end else begin
               oe_pipe[0]   <= oe_i;
               trip_pipe[0] <= trip_i;
               for (int s = 1; s < STAGES; s++) begin
                  oe_pipe[s]   <= oe_pipe[s-1];
                  trip_pipe[s] <= trip_pipe[s-1];
               end
            end
         end
         assign oe_s   = oe_pipe[STAGES-1];
         assign trip_s = trip_pipe[STAGES-1];
      end
   endgenerate

   // Previous sample of each input, used for change and edge detection.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         oe_q   <= 1'b0;
         trip_q <= 1'b0;
      end else begin
         oe_q   <= oe_s;
         trip_q <= trip_s;
      end
   end

   assign oe_lvl_o      = oe_s;
   assign oe_chg_o      = oe_s ^ oe_q;
   assign trip_e_o.rise = trip_s & ~trip_q;
   assign trip_e_o.fall = ~trip_s & trip_q;

endmodule

// File: rtl/lem_window.sv
module lem_window
   import lem_pkg::*;
#(
   parameter int WIN_W = 12,
   parameter int TOG_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cross_i,
   input  logic             chg_i,
   input  logic [WIN_W-1:0] win_len_i,
   output logic             start_o,
   output logic             open_o,
   output logic             last_o,
   output logic [TOG_W-1:0] tog_nxt_o
);

   localparam int              CW      = WIN_W + 1;
   localparam logic [TOG_W-1:0] TOG_MAX = '1;

   win_state_e       state_q;
   logic [WIN_W-1:0] wcnt_q;
   logic [TOG_W-1:0] tog_q;
   logic [TOG_W-1:0] tog_base;

   assign start_o = cross_i && (state_q == WIN_IDLE);
   assign open_o  = (state_q == WIN_OPEN);
   // wcnt_q holds the index of the current edge within the window.
   assign last_o  = open_o && (({1'b0, wcnt_q} + CW'(1)) >= {1'b0, win_len_i});

   always_comb begin
      tog_base  = start_o ? '0 : tog_q;
      tog_nxt_o = tog_base;
      if ((start_o || open_o) && chg_i && (tog_base != TOG_MAX)) begin
         tog_nxt_o = tog_base + TOG_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= WIN_IDLE;
         wcnt_q  <= '0;
         tog_q   <= '0;
      end else if (start_o) begin
         state_q <= WIN_OPEN;
         wcnt_q  <= WIN_W'(1);
         tog_q   <= tog_nxt_o;
      end else if (open_o) begin
         tog_q  <= tog_nxt_o;
         wcnt_q <= wcnt_q + WIN_W'(1);
         if (last_o) begin
            state_q <= WIN_IDLE;
         end
      end
   end

endmodule

// File: rtl/lem_latency.sv
module lem_latency #(
   parameter int LAT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             open_i,
   input  logic             en_i,
   output logic [LAT_W-1:0] lat_nxt_o,
   output logic             low_nxt_o
);

   localparam logic [LAT_W-1:0] LAT_MAX = '1;

   logic [LAT_W-1:0] lat_q;
   logic             low_q;

   always_comb begin
      lat_nxt_o = lat_q;
      low_nxt_o = low_q;
      if (start_i) begin
         lat_nxt_o = en_i ? LAT_W'(1) : '0;
         low_nxt_o = !en_i;
      end else if (open_i && !low_q) begin
         if (!en_i) begin
            low_nxt_o = 1'b1;
         end else if (lat_q != LAT_MAX) begin
            lat_nxt_o = lat_q + LAT_W'(1);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lat_q <= '0;
         low_q <= 1'b0;
      end else begin
         lat_q <= lat_nxt_o;
         low_q <= low_nxt_o;
      end
   end

endmodule

// File: rtl/lem_storm.sv
module lem_storm #(
   parameter int GAP_W   = 10,
   parameter int STORM_W = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cross_i,
   input  logic               recover_i,
   input  logic [GAP_W-1:0]   gap_lim_i,
   output logic               hit_o,
   output logic [STORM_W-1:0] cnt_o
);

   localparam logic [STORM_W-1:0] CNT_MAX = '1;

   logic             armed_q;
   logic [GAP_W-1:0] gap_q;
   logic             hit_now;

   assign hit_now = cross_i && armed_q && (gap_q <= gap_lim_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         gap_q   <= '0;
         hit_o   <= 1'b0;
         cnt_o   <= '0;
      end else begin
         hit_o <= hit_now;
         if (hit_now && (cnt_o != CNT_MAX)) begin
            cnt_o <= cnt_o + STORM_W'(1);
         end
         if (recover_i) begin
            armed_q <= 1'b1;
            gap_q   <= GAP_W'(1);
         end else if (armed_q) begin
            if (cross_i || (gap_q >= gap_lim_i)) begin
               armed_q <= 1'b0;
            end else begin
               gap_q <= gap_q + GAP_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/lockout_event_monitor.sv
module lockout_event_monitor
   import lem_pkg::*;
#(
   parameter int WIN_W       = 12,
   parameter int TOG_W       = 8,
   parameter int LAT_W       = 8,
   parameter int GAP_W       = 10,
   parameter int STORM_W     = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               oe_i,
   input  logic               uv_trip_i,
   input  logic [WIN_W-1:0]   win_len_i,
   input  logic [TOG_W-1:0]   tog_lim_i,
   input  logic [LAT_W-1:0]   lat_lim_i,
   input  logic [GAP_W-1:0]   retrip_gap_i,
   output logic               done_o,
   output logic [TOG_W-1:0]   toggles_o,
   output logic [LAT_W-1:0]   latency_o,
   output logic               chatter_fail_o,
   output logic               latency_fail_o,
   output logic               storm_o,
   output logic [STORM_W-1:0] storm_cnt_o
);

   localparam logic [LAT_W-1:0] LAT_MAX = '1;

   generate
      if (WIN_W < 2) begin : g_bad_win
         $error("WIN_W must be at least 2");
      end
      if (TOG_W < 1) begin : g_bad_tog
         $error("TOG_W must be at least 1");
      end
      if (LAT_W < 2) begin : g_bad_lat
         $error("LAT_W must be at least 2");
      end
      if (GAP_W < 1) begin : g_bad_gap
         $error("GAP_W must be at least 1");
      end
      if (STORM_W < 1) begin : g_bad_storm
         $error("STORM_W must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             oe_lvl, oe_chg;
   edge_t            trip_e;
   logic             win_start, win_open, win_last;
   logic [TOG_W-1:0] tog_nxt;
   logic [LAT_W-1:0] lat_nxt;
   logic             low_nxt;

   lem_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .oe_i     (oe_i),
      .trip_i   (uv_trip_i),
      .oe_lvl_o (oe_lvl),
      .oe_chg_o (oe_chg),
      .trip_e_o (trip_e)
   );

   lem_window #(.WIN_W(WIN_W), .TOG_W(TOG_W)) u_window (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cross_i   (trip_e.rise),
      .chg_i     (oe_chg),
      .win_len_i (win_len_i),
      .start_o   (win_start),
      .open_o    (win_open),
      .last_o    (win_last),
      .tog_nxt_o (tog_nxt)
   );

   lem_latency #(.LAT_W(LAT_W)) u_latency (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (win_start),
      .open_i    (win_open),
      .en_i      (oe_lvl),
      .lat_nxt_o (lat_nxt),
      .low_nxt_o (low_nxt)
   );

   lem_storm #(.GAP_W(GAP_W), .STORM_W(STORM_W)) u_storm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cross_i   (trip_e.rise),
      .recover_i (trip_e.fall),
      .gap_lim_i (retrip_gap_i),
      .hit_o     (storm_o),
      .cnt_o     (storm_cnt_o)
   );

   // Results are taken from next-state values on the closing edge.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_o         <= 1'b0;
         toggles_o      <= '0;
         latency_o      <= '0;
         chatter_fail_o <= 1'b0;
         latency_fail_o <= 1'b0;
      end else begin
         done_o <= win_last;
         if (win_last) begin
            toggles_o      <= tog_nxt;
            latency_o      <= lat_nxt;
            chatter_fail_o <= (tog_nxt > tog_lim_i);
            latency_fail_o <= !low_nxt || (lat_nxt > lat_lim_i) || (lat_nxt == LAT_MAX);
         end
      end
   end

endmodule

// File: rtl/lockout_event_monitor_chk.sv
module lockout_event_monitor_chk #(
   parameter int TOG_W   = 8,
   parameter int LAT_W   = 8,
   parameter int STORM_W = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [TOG_W-1:0]   tog_lim_i,
   input logic [LAT_W-1:0]   lat_lim_i,
   input logic               done_o,
   input logic [TOG_W-1:0]   toggles_o,
   input logic [LAT_W-1:0]   latency_o,
   input logic               chatter_fail_o,
   input logic               latency_fail_o,
   input logic               storm_o,
   input logic [STORM_W-1:0] storm_cnt_o
);

   localparam logic [LAT_W-1:0] LAT_MAX = '1;

   // R2: a window spans at least two edges, so done never repeats back to back
   p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R8: result outputs move only together with the done pulse
   p_hold_results_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((toggles_o != $past(toggles_o)) || (latency_o != $past(latency_o)) ||
       (chatter_fail_o != $past(chatter_fail_o)) ||
       (latency_fail_o != $past(latency_fail_o))) |-> done_o);

   // R4: a count within the limit never reports chatter
   p_chatter_ok_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && (toggles_o <= $past(tog_lim_i))) |-> !chatter_fail_o);

   // R6: a passing latency lies within the limit
   p_lat_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !latency_fail_o) |-> (latency_o <= $past(lat_lim_i)));

   // R7: a saturated latency is always a failure
   p_sat_fails_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && (latency_o == LAT_MAX)) |-> latency_fail_o);

   // R9: the storm count moves only with a storm pulse
   p_storm_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (storm_cnt_o != $past(storm_cnt_o)) |-> storm_o);

endmodule

bind lockout_event_monitor lockout_event_monitor_chk #(
   .TOG_W   (TOG_W),
   .LAT_W   (LAT_W),
   .STORM_W (STORM_W)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .tog_lim_i      (tog_lim_i),
   .lat_lim_i      (lat_lim_i),
   .done_o         (done_o),
   .toggles_o      (toggles_o),
   .latency_o      (latency_o),
   .chatter_fail_o (chatter_fail_o),
   .latency_fail_o (latency_fail_o),
   .storm_o        (storm_o),
   .storm_cnt_o    (storm_cnt_o)
);

// File: tb/lockout_event_monitor_bench.sv
`timescale 1ns/1ps
module lockout_event_monitor_bench;

   localparam int LAT_MAX = 255;

   logic       clk = 1'b0;
   logic       rst_ni;
   logic       oe;
   logic       trip;
   logic [11:0] win_len;
   logic [7:0]  tog_lim;
   logic [7:0]  lat_lim;
   logic [9:0]  gap;
   logic        done_o;
   logic [7:0]  toggles_o;
   logic [7:0]  latency_o;
   logic        chatter_fail_o;
   logic        latency_fail_o;
   logic        storm_o;
   logic [7:0]  storm_cnt_o;

   always #2 clk = ~clk;

   lockout_event_monitor u_lockout_event_monitor (
      .clk_i          (clk),
      .rst_ni         (rst_ni),
      .oe_i           (oe),
      .uv_trip_i      (trip),
      .win_len_i      (win_len),
      .tog_lim_i      (tog_lim),
      .lat_lim_i      (lat_lim),
      .retrip_gap_i   (gap),
      .done_o         (done_o),
      .toggles_o      (toggles_o),
      .latency_o      (latency_o),
      .chatter_fail_o (chatter_fail_o),
      .latency_fail_o (latency_fail_o),
      .storm_o        (storm_o),
      .storm_cnt_o    (storm_cnt_o)
   );

   typedef struct {
      int tog;
      int lat;
      bit cf;
      bit lf;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails = 0;
   int   storm_seen = 0;
   bit   score_on = 1'b0;
   bit   finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic logic pbit(input logic [63:0] p, input int i);
      return p[(i > 63) ? 63 : i];
   endfunction

   // Expected results built from R3 to R7.
   function automatic exp_t model(input int w, input logic [63:0] op, input logic prev,
                                  input int tlim, input int llim);
      exp_t e;
      logic last = prev;
      bit   low = 1'b0;
      e.tog = 0;
      e.lat = w;
      for (int i = 0; i < w; i++) begin
         if (pbit(op, i) != last) e.tog++;
         last = pbit(op, i);
      end
      for (int i = 0; i < w; i++) begin
         if (pbit(op, i) == 1'b0) begin
            low = 1'b1;
            e.lat = i;
            break;
         end
      end
      if (e.lat > LAT_MAX) e.lat = LAT_MAX;
      e.cf = (e.tog > tlim);
      e.lf = !low || (e.lat > llim) || (e.lat == LAT_MAX);
      return e;
   endfunction

   // Monitor: pops one expected item per done pulse.
   always @(negedge clk) begin
      if (rst_ni && storm_o) storm_seen++;
      if (rst_ni && done_o && score_on) begin
         if (q.size() == 0) begin
            check(1'b0, "R2", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(toggles_o == e.tog, "R3", "toggle count", toggles_o, e.tog);
            check(latency_o == e.lat, "R5", "latency", latency_o, e.lat);
            check(chatter_fail_o == e.cf, "R4", "chatter flag", chatter_fail_o, e.cf);
            check(latency_fail_o == e.lf, "R6", "latency flag", latency_fail_o, e.lf);
         end
      end
   end

   task automatic idle(input int n, input logic prev, input bit wiggle);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         trip = 1'b0;
         oe = (wiggle && ((n - 1 - k) % 2 == 1)) ? ~prev : prev;
      end
   endtask

   // Driver: pushes the expected item, then plays one excursion.
   task automatic run_event(input int w, input logic [63:0] op, input logic [63:0] tp,
                            input logic prev, input int tlim, input int llim,
                            input bit wiggle, input int gp, input bit storm_at_close);
      exp_t  e;
      logic  lastv;
      e = model(w, op, prev, tlim, llim);
      @(negedge clk);
      win_len = 12'(w);
      tog_lim = 8'(tlim);
      lat_lim = 8'(llim);
      gap     = 10'(gp);
      score_on = 1'b1;
      q.push_back(e);
      idle(12, prev, wiggle);
      lastv = pbit(op, w - 1);
      for (int i = 0; i <= w + 6; i++) begin
         @(negedge clk);
         if (i == w - 1) check(done_o == 1'b0, "R2", "done early", done_o, 0);
         if (i == w) begin
            check(done_o == 1'b1, "R2", "done at close", done_o, 1);
            check(storm_o == storm_at_close, "R9", "storm at close", storm_o, storm_at_close);
         end
         if (i == w + 1) check(done_o == 1'b0, "R2", "done width", done_o, 0);
         if (i > w + 1) check(done_o == 1'b0, "R2", "no second window", done_o, 0);
         if (i < w) oe = pbit(op, i);
         else oe = (wiggle && ((i - w) % 2 == 0)) ? ~lastv : lastv;
         trip = pbit(tp, i);
      end
      @(negedge clk);
      trip = 1'b0;
      idle(4, oe, 1'b0);
      check(q.size() == 0, "R2", "pending results", q.size(), 0);
      check(toggles_o == e.tog, "R8", "toggles held", toggles_o, e.tog);
      check(latency_o == e.lat, "R8", "latency held", latency_o, e.lat);
   endtask

   task automatic storm_seq(input int gp, input int d, input bit hit);
      int base_cnt;
      int base_seen;
      score_on = 1'b0;
      @(negedge clk);
      gap = 10'(gp);
      win_len = 12'd8;
      idle(40, 1'b0, 1'b0);
      base_cnt  = storm_cnt_o;
      base_seen = storm_seen;
      for (int k = 0; k < 3; k++) begin @(negedge clk); trip = 1'b1; end
      for (int k = 0; k < d; k++) begin @(negedge clk); trip = 1'b0; end
      for (int k = 0; k < 3; k++) begin @(negedge clk); trip = 1'b1; end
      idle(40, 1'b0, 1'b0);
      check(storm_cnt_o == base_cnt + int'(hit), "R9", "storm count", storm_cnt_o, base_cnt + int'(hit));
      check(storm_seen - base_seen == int'(hit), "R9", "storm pulses", storm_seen - base_seen, int'(hit));
   endtask

   initial begin
      rst_ni = 1'b0;
      oe = 1'b0;
      trip = 1'b0;
      win_len = '0;
      tog_lim = '0;
      lat_lim = '0;
      gap = '0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(done_o == 0, "R1", "done", done_o, 0);
      check(toggles_o == 0, "R1", "toggles", toggles_o, 0);
      check(latency_o == 0, "R1", "latency", latency_o, 0);
      check(chatter_fail_o == 0 && latency_fail_o == 0, "R1", "fail flags",
            {chatter_fail_o, latency_fail_o}, 0);
      check(storm_o == 0 && storm_cnt_o == 0, "R1", "storm", storm_cnt_o, 0);

      // R2 R3 R5: clean disable after five edges
      run_event(16, 64'h1F, 64'hF, 1'b1, 2, 8, 1'b0, 0, 1'b0);
      // R4: chatter above limit, then exactly at limit
      run_event(16, 64'h155, 64'hF, 1'b1, 4, 8, 1'b0, 0, 1'b0);
      run_event(16, 64'h155, 64'hF, 1'b1, 9, 8, 1'b0, 0, 1'b0);
      // R6: latency one above the limit, then equal to it
      run_event(20, 64'hFFF, 64'hF, 1'b1, 4, 11, 1'b0, 0, 1'b0);
      run_event(20, 64'hFFF, 64'hF, 1'b1, 4, 12, 1'b0, 0, 1'b0);
      // R5: enable already low at the crossing
      run_event(16, 64'h0, 64'hF, 1'b0, 0, 0, 1'b0, 0, 1'b0);
      // R6: enable never drops inside the window
      run_event(20, '1 ^ 64'h0, 64'hF, 1'b1, 4, 100, 1'b0, 0, 1'b0);
      // R7: latency saturates in a long window
      run_event(300, '1, 64'hF, 1'b1, 4, 255, 1'b0, 0, 1'b0);
      // R3 R8: enable wiggling before and after the window
      run_event(16, 64'h1F, 64'hF, 1'b1, 2, 8, 1'b1, 0, 1'b0);
      // R2: a second trip rise inside the window is ignored
      run_event(16, 64'h7, 64'hE3, 1'b1, 2, 8, 1'b0, 0, 1'b0);
      check(storm_cnt_o == 0, "R9", "no storm with zero gap", storm_cnt_o, 0);
      // R2 R9: re-trip on the closing edge, with an enable change there too
      run_event(10, 64'hFFFF_FFFF_FFFF_FE07, 64'hFFFF_FFFF_FFFF_FE01, 1'b1, 2, 5, 1'b0, 20, 1'b1);
      check(storm_cnt_o == 1, "R9", "storm count after close", storm_cnt_o, 1);

      // R9: re-trip inside, at and beyond the hold-off
      storm_seq(5, 3, 1'b1);
      storm_seq(5, 5, 1'b1);
      storm_seq(5, 6, 1'b0);
      storm_seq(0, 1, 1'b0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule